// File: doc/BRIEF.md
# Port Bus-Width Matching Sequencer

This block adapts a 36-bit memory word to an external port that may be 36, 18 or 9 bits wide. Each 36-bit word is split into four 9-bit lanes. In the 18-bit mode lanes travel in pairs; in the 9-bit mode they travel one at a time. A 2-bit step counter chooses which half or lane moves in the current cycle. It walks upward when the low part is sent first and downward when the high part is sent first.

On reads, the block places the chosen half or lane on the low external bits and holds every other bit at zero. On writes, it copies the external data into every lane position and enables only the lanes of the current step, so the memory is updated one piece per cycle. It tells the external word-address counter to move on after the final step of a word. It can also return the word address on the data pins, using one cycle in the 36-bit and 18-bit modes and two cycles in the 9-bit mode.

Top module: `bus_width_seq`

## Requirements
- R1: The configuration pins `cfg_narrow`/`cfg_byte` decode as follows: 0/x gives 36-bit mode, 1/0 gives 18-bit mode and 1/1 gives 9-bit mode. Outside writes, `ext_lane_oe` is 4'b1111, 4'b0011 or 4'b0001 in those modes. In 36-bit mode every read presents the full `mem_rdata`, and `cfg_msb_first` has no effect.
- R2: With `cfg_msb_first`=0, successive counted steps read bits 17:0 and then 35:18 in 18-bit mode. In 9-bit mode they read lanes 0,1,2,3, where lane k is bits 9k+8:9k. The chosen piece sits at the low end of `ext_rdata`.
- R3: With `cfg_msb_first`=1, the order is reversed: 35:18 and then 17:0 in 18-bit mode, and lanes 3,2,1,0 in 9-bit mode.
- R4: The step moves only in cycles where `ext_count`=1 and `ext_rdback`=0. In all other cycles it holds its value.
- R5: `word_adv` is 1 in a counted cycle whose step is the final one of the word. In 36-bit mode this is every counted cycle. The step after a final step is the first step again.
- R6: When `ext_load`=1, the current cycle uses the first step: step 0 for low-first order, and the last step for high-first order. With `ext_load`=1 and `ext_count`=0, the step stays at the first step.
- R7: A write (`ext_write`=1) sets only the `mem_lane_we` bits of the current step: 4'b1111 in 36-bit mode, 4'b0011 or 4'b1100 for the halves, and a single bit per lane. Each enabled lane of `mem_wdata` carries the matching external bits: the full word, a copy of bits 17:0, or a copy of bits 8:0.
- R8: While `ext_rdback`=1, no lane is written and `word_adv` stays 0. The address is returned as follows. In 36-bit mode it appears on bits AW-1:0. In 18-bit mode bits AW:0 carry {address, step bit 0}. In 9-bit mode the first cycle carries address bits 14:6, and the next cycle carries {address bits 5:0, step}.
- R9: The configuration pins take effect one cycle after they are applied. Any change to the decoded configuration restarts the step at the first step of the new configuration.
- R10: In 9-bit mode `ext_rdata` bits 35:9 are zero. During writes, `ext_rdata` is zero and `ext_lane_oe` is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_narrow | input | 1 | 1 selects a narrow external width |
| cfg_byte | input | 1 | With cfg_narrow: 1 selects 9-bit, 0 selects 18-bit |
| cfg_msb_first | input | 1 | 1 transfers the most significant part first |
| ext_load | input | 1 | New address loaded this cycle; restarts the step |
| ext_count | input | 1 | Word counter in increment mode |
| ext_write | input | 1 | Current transfer is a write |
| ext_rdback | input | 1 | Return the address instead of data |
| ext_wdata | input | 36 | External write data (low bits used in narrow modes) |
| mem_rdata | input | 36 | Word read from the current address |
| word_addr | input | AW | Current word address, for readback |
| ext_rdata | output | 36 | External read data |
| ext_lane_oe | output | 4 | Per-lane drive enable for the external bus |
| mem_wdata | output | 36 | Word data toward memory |
| mem_lane_we | output | 4 | Per-lane write enables toward memory |
| word_adv | output | 1 | Advance the word-address counter |

## Verification
A wrong step count shows up in the same cycle on `ext_rdata`, because a different half or lane is selected. It also shows up in `mem_lane_we` during writes, and in whether `word_adv` is raised on the final step. All three are checked in every cycle of each burst. A stuck or reversed counter is therefore caught within one word, which is four cycles at most. A configuration register that fails to update, or fails to restart the step, changes the lane pattern and `ext_lane_oe` in the cycle after the change. A bad readback phase corrupts the second 9-bit address cycle, or the read that follows it.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
    localparam int LANE_W   = 9;
    localparam int N_LANES  = 4;
    localparam int WORD_W   = LANE_W * N_LANES;
    localparam int STEP_W   = 2;
    localparam int RB_SPLIT = 6;

    typedef enum logic [1:0] {
        BW_FULL = 2'd0,
        BW_HALF = 2'd1,
        BW_LANE = 2'd2
    } bw_mode_e;

    typedef struct packed {
        bw_mode_e mode;
        logic     msb_first;
    } bw_cfg_t;

    typedef logic [STEP_W-1:0]  step_t;
    typedef logic [N_LANES-1:0] lane_mask_t;

    function automatic bw_cfg_t decode_cfg(input logic narrow, input logic byte_sel,
                                           input logic msb_first);
        bw_cfg_t c;
        if (!narrow) begin
            c.mode      = BW_FULL;
            c.msb_first = 1'b0;
        end else begin
            c.mode      = byte_sel ? BW_LANE : BW_HALF;
            c.msb_first = msb_first;
        end
        return c;
    endfunction

    function automatic step_t last_step(input bw_mode_e m);
        case (m)
            BW_HALF: return step_t'(1);
            BW_LANE: return step_t'(3);
            default: return step_t'(0);
        endcase
    endfunction

    function automatic step_t first_step(input bw_cfg_t c);
        return c.msb_first ? last_step(c.mode) : step_t'(0);
    endfunction

    function automatic step_t final_step(input bw_cfg_t c);
        return c.msb_first ? step_t'(0) : last_step(c.mode);
    endfunction

    function automatic lane_mask_t drive_lanes(input bw_mode_e m);
        case (m)
            BW_HALF: return 4'b0011;
            BW_LANE: return 4'b0001;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic lane_mask_t step_lanes(input bw_mode_e m, input step_t s);
        case (m)
            BW_HALF: return s[0] ? 4'b1100 : 4'b0011;
            BW_LANE: return lane_mask_t'(1) << s;
            default: return 4'b1111;
        endcase
    endfunction
endpackage

// File: rtl/bwm_step_ctr.sv
module bwm_step_ctr
    import bwm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bw_cfg_t cfg_cur,
    input  bw_cfg_t cfg_new,
    input  logic    cfg_chg,
    input  logic    load,
    input  logic    advance_en,
    output step_t   cur_step,
    output logic    word_adv
);
    step_t sc_q;
    step_t sc_next;
    logic  at_final;

    always_comb begin
        cur_step = load ? first_step(cfg_cur) : sc_q;
        at_final = (cur_step == final_step(cfg_cur));
        word_adv = advance_en && at_final;
        if (cfg_chg)
            sc_next = first_step(cfg_new);
        else if (!advance_en)
            sc_next = cur_step;
        else if (at_final)
            sc_next = first_step(cfg_cur);
        else if (cfg_cur.msb_first)
            sc_next = cur_step - step_t'(1);
        else
            sc_next = cur_step + step_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) sc_q <= '0;
        else     sc_q <= sc_next;
    end

    // R4: no count, no load, no config change -> step holds
    a_r4_step_holds: assert property (@(posedge clk) disable iff (rst)
        (!advance_en && !load && !cfg_chg) |=> $stable(sc_q));

    // R2: low-first order walks upward
    a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
        (advance_en && !load && !cfg_chg && !cfg_cur.msb_first && !at_final)
        |=> (sc_q == $past(sc_q) + step_t'(1)));

    // R3: high-first order walks downward
    a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
        (advance_en && !load && !cfg_chg && cfg_cur.msb_first && !at_final)
        |=> (sc_q == $past(sc_q) - step_t'(1)));

    // R5: after the word advances, the step restarts
    a_r5_wrap_first: assert property (@(posedge clk) disable iff (rst)
        (word_adv && !cfg_chg) |=> (sc_q == first_step(cfg_cur)));
endmodule

// File: rtl/bwm_rd_path.sv
module bwm_rd_path
    import bwm_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  bw_mode_e          mode,
    input  step_t             cur_step,
    input  logic              rdback,
    input  logic              write,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [AW-1:0]     word_addr,
    output logic [WORD_W-1:0] ext_rdata,
    output lane_mask_t        ext_lane_oe
);
    localparam int HALF_W = 2 * LANE_W;
    localparam int RB_W   = LANE_W + RB_SPLIT;

    logic            rb_phase;
    logic [RB_W-1:0] addr_ext;

    always_ff @(posedge clk) begin
        if (rst)                           rb_phase <= 1'b0;
        else if (rdback && mode == BW_LANE) rb_phase <= ~rb_phase;
        else                               rb_phase <= 1'b0;
    end

    always_comb begin
        ext_rdata   = '0;
        ext_lane_oe = '0;
        addr_ext    = '0;
        addr_ext[AW-1:0] = word_addr;
        if (rdback) begin
            ext_lane_oe = drive_lanes(mode);
            case (mode)
                BW_FULL: ext_rdata[AW-1:0] = word_addr;
                BW_HALF: ext_rdata[AW:0]   = {word_addr, cur_step[0]};
                default: begin
                    if (!rb_phase)
                        ext_rdata[LANE_W-1:0] = addr_ext[RB_W-1:RB_SPLIT];
                    else
                        ext_rdata[RB_SPLIT+STEP_W-1:0] = {addr_ext[RB_SPLIT-1:0], cur_step};
                end
            endcase
        end else if (!write) begin
            ext_lane_oe = drive_lanes(mode);
            case (mode)
                BW_FULL: ext_rdata = mem_rdata;
                BW_HALF: ext_rdata[HALF_W-1:0] =
                             mem_rdata[int'(cur_step[0]) * HALF_W +: HALF_W];
                default: ext_rdata[LANE_W-1:0] =
                             mem_rdata[int'(cur_step) * LANE_W +: LANE_W];
            endcase
        end
    end

    // R8: second 9-bit readback cycle is followed by the first again
    a_r8_phase_alternates: assert property (@(posedge clk) disable iff (rst)
        (rdback && rb_phase) |=> !rb_phase);

    // R10: upper pins quiet in 9-bit mode
    a_r10_upper_quiet: assert property (@(posedge clk) disable iff (rst)
        (mode == BW_LANE) |-> (ext_rdata[WORD_W-1:LANE_W] == '0));
endmodule

// File: rtl/bwm_wr_steer.sv
module bwm_wr_steer
    import bwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bw_mode_e          mode,
    input  step_t             cur_step,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] ext_wdata,
    output logic [WORD_W-1:0] mem_wdata,
    output lane_mask_t        mem_lane_we
);
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        always_comb begin
            case (mode)
                BW_FULL: mem_wdata[g*LANE_W +: LANE_W] = ext_wdata[g*LANE_W +: LANE_W];
                BW_HALF: mem_wdata[g*LANE_W +: LANE_W] = ext_wdata[(g%2)*LANE_W +: LANE_W];
                default: mem_wdata[g*LANE_W +: LANE_W] = ext_wdata[LANE_W-1:0];
            endcase
        end
    end

    assign mem_lane_we = wr_en ? step_lanes(mode, cur_step) : '0;

    // R7: a 9-bit write touches at most one lane
    a_r7_single_lane: assert property (@(posedge clk) disable iff (rst)
        (mode == BW_LANE) |-> $onehot0(mem_lane_we));

    // R7: an 18-bit write touches a whole half or nothing
    a_r7_half_pair: assert property (@(posedge clk) disable iff (rst)
        (mode == BW_HALF) |-> ($countones(mem_lane_we) == 0 || $countones(mem_lane_we) == 2));
endmodule

// File: rtl/bus_width_seq.sv
module bus_width_seq
    import bwm_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_narrow,
    input  logic              cfg_byte,
    input  logic              cfg_msb_first,
    input  logic              ext_load,
    input  logic              ext_count,
    input  logic              ext_write,
    input  logic              ext_rdback,
    input  logic [WORD_W-1:0] ext_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [AW-1:0]     word_addr,
    output logic [WORD_W-1:0] ext_rdata,
    output logic [N_LANES-1:0] ext_lane_oe,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [N_LANES-1:0] mem_lane_we,
    output logic              word_adv
);
    bw_cfg_t cfg_in;
    bw_cfg_t cfg_q;
    logic    cfg_chg;
    step_t   cur_step;
    logic    advance_en;
    logic    wr_en;

    assign cfg_in     = decode_cfg(cfg_narrow, cfg_byte, cfg_msb_first);
    assign cfg_chg    = (cfg_in != cfg_q);
    assign advance_en = ext_count && !ext_rdback;
    assign wr_en      = ext_write && !ext_rdback;

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '{mode: BW_FULL, msb_first: 1'b0};
        else     cfg_q <= cfg_in;
    end

    bwm_step_ctr u_step (
        .clk        (clk),
        .rst        (rst),
        .cfg_cur    (cfg_q),
        .cfg_new    (cfg_in),
        .cfg_chg    (cfg_chg),
        .load       (ext_load),
        .advance_en (advance_en),
        .cur_step   (cur_step),
        .word_adv   (word_adv)
    );

    bwm_rd_path #(.AW(AW)) u_rd (
        .clk         (clk),
        .rst         (rst),
        .mode        (cfg_q.mode),
        .cur_step    (cur_step),
        .rdback      (ext_rdback),
        .write       (ext_write),
        .mem_rdata   (mem_rdata),
        .word_addr   (word_addr),
        .ext_rdata   (ext_rdata),
        .ext_lane_oe (ext_lane_oe)
    );

    bwm_wr_steer u_wr (
        .clk         (clk),
        .rst         (rst),
        .mode        (cfg_q.mode),
        .cur_step    (cur_step),
        .wr_en       (wr_en),
        .ext_wdata   (ext_wdata),
        .mem_wdata   (mem_wdata),
        .mem_lane_we (mem_lane_we)
    );

    // R8: readback never writes or advances the word
    a_r8_rdback_inert: assert property (@(posedge clk) disable iff (rst)
        ext_rdback |-> (mem_lane_we == '0 && !word_adv));

    // R10: nothing driven outward during a write
    a_r10_write_undriven: assert property (@(posedge clk) disable iff (rst)
        (ext_write && !ext_rdback) |-> (ext_lane_oe == '0));

    // R5: the word only advances in increment mode
    a_r5_adv_needs_count: assert property (@(posedge clk) disable iff (rst)
        word_adv |-> ext_count);
endmodule

// File: tb/bus_width_seq_tb.sv
module bus_width_seq_tb_top;
    localparam int AW = 15;
    localparam logic [8:0]  L0 = 9'h011, L1 = 9'h122, L2 = 9'h0A3, L3 = 9'h1B4;
    localparam logic [35:0] MEM   = {L3, L2, L1, L0};
    localparam logic [35:0] WDAT  = 36'hA5C3_9E17B;
    localparam logic [14:0] ADDR  = 15'h5A3C;
    localparam int NV = 31;

    // {narrow,byte,msb}, {load,count,write}, chk, exp code, exp we, exp adv
    // code: 0-3 lane k, 4 low half, 5 high half, 6 full word, 7 zero (write)
    localparam logic [14:0] VEC [0:NV-1] = '{
        {3'b100, 3'b000, 1'b0, 3'd0, 4'b0000, 1'b0}, // R9 config change
        {3'b100, 3'b110, 1'b1, 3'd4, 4'b0000, 1'b0}, // R6 load
        {3'b100, 3'b010, 1'b1, 3'd5, 4'b0000, 1'b1},
        {3'b100, 3'b000, 1'b1, 3'd4, 4'b0000, 1'b0}, // R4 hold
        {3'b100, 3'b010, 1'b1, 3'd4, 4'b0000, 1'b0},
        {3'b100, 3'b000, 1'b1, 3'd5, 4'b0000, 1'b0}, // R4 hold
        {3'b101, 3'b000, 1'b0, 3'd0, 4'b0000, 1'b0}, // R9 change restarts step
        {3'b101, 3'b010, 1'b1, 3'd5, 4'b0000, 1'b0},
        {3'b101, 3'b010, 1'b1, 3'd4, 4'b0000, 1'b1},
        {3'b101, 3'b111, 1'b1, 3'd7, 4'b1100, 1'b0}, // R6 load, high first
        {3'b101, 3'b011, 1'b1, 3'd7, 4'b0011, 1'b1},
        {3'b110, 3'b000, 1'b0, 3'd0, 4'b0000, 1'b0},
        {3'b110, 3'b110, 1'b1, 3'd0, 4'b0000, 1'b0},
        {3'b110, 3'b010, 1'b1, 3'd1, 4'b0000, 1'b0},
        {3'b110, 3'b010, 1'b1, 3'd2, 4'b0000, 1'b0},
        {3'b110, 3'b010, 1'b1, 3'd3, 4'b0000, 1'b1},
        {3'b110, 3'b011, 1'b1, 3'd7, 4'b0001, 1'b0},
        {3'b110, 3'b110, 1'b1, 3'd0, 4'b0000, 1'b0}, // R6 mid-word reload
        {3'b110, 3'b010, 1'b1, 3'd1, 4'b0000, 1'b0},
        {3'b111, 3'b000, 1'b0, 3'd0, 4'b0000, 1'b0}, // R9
        {3'b111, 3'b010, 1'b1, 3'd3, 4'b0000, 1'b0},
        {3'b111, 3'b010, 1'b1, 3'd2, 4'b0000, 1'b0},
        {3'b111, 3'b011, 1'b1, 3'd7, 4'b0010, 1'b0},
        {3'b111, 3'b010, 1'b1, 3'd0, 4'b0000, 1'b1},
        {3'b111, 3'b100, 1'b1, 3'd3, 4'b0000, 1'b0}, // R6 load without count
        {3'b111, 3'b000, 1'b1, 3'd3, 4'b0000, 1'b0},
        {3'b001, 3'b000, 1'b0, 3'd0, 4'b0000, 1'b0},
        {3'b001, 3'b010, 1'b1, 3'd6, 4'b0000, 1'b1},
        {3'b001, 3'b011, 1'b1, 3'd7, 4'b1111, 1'b1},
        {3'b001, 3'b000, 1'b1, 3'd6, 4'b0000, 1'b0},
        {3'b010, 3'b010, 1'b1, 3'd6, 4'b0000, 1'b1}  // R1 0/1 is still 36-bit
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_narrow = 0, cfg_byte = 0, cfg_msb_first = 0;
    logic        ext_load = 0, ext_count = 0, ext_write = 0, ext_rdback = 0;
    logic [35:0] ext_wdata = WDAT;
    logic [35:0] mem_rdata = MEM;
    logic [AW-1:0] word_addr = ADDR;
    logic [35:0] ext_rdata, mem_wdata;
    logic [3:0]  ext_lane_oe, mem_lane_we;
    logic        word_adv;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bus_width_seq #(.AW(AW)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_narrow(cfg_narrow), .cfg_byte(cfg_byte), .cfg_msb_first(cfg_msb_first),
        .ext_load(ext_load), .ext_count(ext_count), .ext_write(ext_write),
        .ext_rdback(ext_rdback), .ext_wdata(ext_wdata), .mem_rdata(mem_rdata),
        .word_addr(word_addr), .ext_rdata(ext_rdata), .ext_lane_oe(ext_lane_oe),
        .mem_wdata(mem_wdata), .mem_lane_we(mem_lane_we), .word_adv(word_adv)
    );

    task automatic check(input string what, input logic [35:0] act, input logic [35:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] cfg, input logic [2:0] ctl, input logic rb);
        {cfg_narrow, cfg_byte, cfg_msb_first} = cfg;
        {ext_load, ext_count, ext_write} = ctl;
        ext_rdback = rb;
    endtask

    function automatic logic [35:0] exp_data(input logic [2:0] code);
        case (code)
            3'd0: return {27'd0, L0};
            3'd1: return {27'd0, L1};
            3'd2: return {27'd0, L2};
            3'd3: return {27'd0, L3};
            3'd4: return {18'd0, L1, L0};
            3'd5: return {18'd0, L3, L2};
            3'd6: return MEM;
            default: return 36'd0;
        endcase
    endfunction

    function automatic logic [3:0] exp_oe(input logic [2:0] code);
        case (code)
            3'd4, 3'd5: return 4'b0011;
            3'd6:       return 4'b1111;
            3'd7:       return 4'b0000;
            default:    return 4'b0001;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // reset state: 36-bit, full word, nothing written or advanced
        check("R1 reset rdata", ext_rdata, MEM);
        check("R1 reset oe", {32'd0, ext_lane_oe}, {32'd0, 4'b1111});
        check("R7 reset we", {32'd0, mem_lane_we}, 36'd0);
        check("R5 reset adv", {35'd0, word_adv}, 36'd0);

        for (int i = 0; i < NV; i++) begin
            logic [14:0] v;
            string req;
            v = VEC[i];
            @(negedge clk);
            drive(v[14:12], v[11:9], 1'b0);
            #2;
            if (v[8]) begin
                if (!v[14])     req = "R1";
                else if (v[12]) req = "R3";
                else            req = "R2";
                check($sformatf("%s vec %0d rdata", req, i), ext_rdata, exp_data(v[7:5]));
                check($sformatf("R10 vec %0d oe", i), {32'd0, ext_lane_oe}, {32'd0, exp_oe(v[7:5])});
                check($sformatf("R7 vec %0d we", i), {32'd0, mem_lane_we}, {32'd0, v[4:1]});
                check($sformatf("R5 vec %0d adv", i), {35'd0, word_adv}, {35'd0, v[0]});
                for (int k = 0; k < 4; k++) begin
                    if (v[1 + k]) begin
                        logic [8:0] e;
                        if (!v[14])     e = WDAT[9*k +: 9];
                        else if (v[13]) e = WDAT[8:0];
                        else            e = WDAT[9*(k%2) +: 9];
                        check($sformatf("R7 vec %0d wdata lane %0d", i, k),
                              {27'd0, mem_wdata[9*k +: 9]}, {27'd0, e});
                    end
                end
            end
        end

        // R8 readback, 36-bit
        @(negedge clk); drive(3'b000, 3'b000, 1'b1); #2;
        check("R8 readback 36", ext_rdata, {21'd0, ADDR});
        // R8 readback, 18-bit after one counted step
        @(negedge clk); drive(3'b100, 3'b000, 1'b0);
        @(negedge clk); drive(3'b100, 3'b110, 1'b0);
        @(negedge clk); drive(3'b100, 3'b011, 1'b1); #2;
        check("R8 readback 18", ext_rdata, {20'd0, ADDR, 1'b1});
        check("R8 readback 18 no write", {32'd0, mem_lane_we}, 36'd0);
        check("R8 readback 18 no adv", {35'd0, word_adv}, 36'd0);
        @(negedge clk); drive(3'b100, 3'b010, 1'b0); #2;
        check("R8 step held over readback", ext_rdata, exp_data(3'd5));
        check("R5 adv after readback", {35'd0, word_adv}, 36'd1);
        // R8 readback, 9-bit two cycles at step 2
        @(negedge clk); drive(3'b110, 3'b000, 1'b0);
        @(negedge clk); drive(3'b110, 3'b110, 1'b0);
        @(negedge clk); drive(3'b110, 3'b010, 1'b0);
        @(negedge clk); drive(3'b110, 3'b010, 1'b1); #2;
        check("R8 readback 9 upper", ext_rdata, {27'd0, ADDR[14:6]});
        @(negedge clk); drive(3'b110, 3'b010, 1'b1); #2;
        check("R8 readback 9 lower", ext_rdata, {28'd0, ADDR[5:0], 2'b10});
        @(negedge clk); drive(3'b110, 3'b000, 1'b0); #2;
        check("R8 step held in 9-bit", ext_rdata, exp_data(3'd2));
        check("R10 9-bit oe", {32'd0, ext_lane_oe}, {32'd0, 4'b0001});

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule